// File: doc/BRIEF.md
# Block Erase Sequencer with Suspend

This block sits behind a flash command decoder and runs multi-block erases. When the decoder reports a block-erase confirmation with a block index, the sequencer records that block in a pending bitmap and opens an append window. Further confirmations arriving while the window is open add more blocks and restart the window. When the window runs out, the sequencer erases every pending block in turn. The cell erase is modelled as a fixed number of clock cycles per block.

The host polls progress through three status bits. A busy bit is high while an erase is in progress. A window-closed bit reads 0 while blocks can still be appended and 1 once erasing has begun. A toggle bit inverts on each status read while work is active. An erase may be suspended, so that other blocks can be read, and later resumed from the point where it stopped. A reset command issued during an erase drops all pending work and holds the sequencer in a recovery period before it accepts new commands. The window and recovery lengths are counted in pulses of an external timer tick.

Top module: `erase_sequencer`

## Requirements
- R1: After reset, busy, toggle, window_closed, erasing, suspended and recovering are 0 and cur_block is 0.
- R2: A cmd_block pulse while idle opens the append window on the next edge: busy=1, window_closed=0, erasing=0.
- R3: With no further cmd_block, the window closes on the WINDOW_TICKS-th tick pulse. On that same edge window_closed becomes 1 and erasing starts.
- R4: A cmd_block pulse while the window is open adds its block and restarts the window count from zero. Repeating a block already pending is harmless.
- R5: Pending blocks are erased in ascending index order, each exactly once. erasing stays high for ERASE_CYCLES cycles per block, plus one cycle for each suspend taken during that block. After the last block, busy and window_closed return to 0.
- R6: toggle inverts on each status_rd pulse while the window is open or a block is erasing. In every other state it holds its value.
- R7: cmd_suspend while erasing sets suspended=1 and erasing=0 and freezes progress. cur_block holds its value while suspended. cmd_suspend in any other state is ignored.
- R8: cmd_resume while suspended returns to erasing the same block with its remaining cycles. The erase may be suspended again later.
- R9: cmd_resume while not suspended has no effect.
- R10: cmd_reset while busy discards all pending blocks and raises recovering (busy=0) for RECOVER_TICKS tick pulses. Commands are ignored during recovery. cmd_reset while idle has no effect.
- R11: cmd_block pulses during erasing or suspension are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer pulse for the window and recovery counts |
| cmd_block | input | 1 | Block-erase confirmation pulse carrying blk_idx |
| blk_idx | input | $clog2(NUM_BLOCKS) | Block index for cmd_block |
| cmd_suspend | input | 1 | Erase suspend command pulse |
| cmd_resume | input | 1 | Erase resume command pulse |
| cmd_reset | input | 1 | Reset command pulse |
| status_rd | input | 1 | Status read strobe |
| busy | output | 1 | Window open, erasing or suspended |
| toggle | output | 1 | Toggle bit for polling |
| window_closed | output | 1 | 0 while blocks may be appended, 1 once erasing began |
| erasing | output | 1 | A block is actively being erased |
| suspended | output | 1 | Erase is suspended |
| recovering | output | 1 | Post-reset recovery period |
| cur_block | output | $clog2(NUM_BLOCKS) | Block being erased or suspended |

## Verification
The hardest situation to reach is a suspend in the middle of a block, followed by a second suspend on the same block. In that case the remaining cycle count must survive both pauses, and the block's total active time must equal ERASE_CYCLES plus the number of suspends. The stimulus gets there by closing the window with a counted run of ticks and then waiting a known number of cycles before each suspend and resume. A monitor measures the active cycles per block against a queue of expected block indices. A reset fired a few cycles into an erase is used to reach the recovery state, and a block command is issued inside that state to show it is dropped.

// File: rtl/erase_sequencer.sv
module erase_sequencer #(
  parameter int NUM_BLOCKS    = 8,
  parameter int WINDOW_TICKS  = 80,
  parameter int RECOVER_TICKS = 5,
  parameter int ERASE_CYCLES  = 40,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int WW = $clog2(WINDOW_TICKS + 1),
  localparam int RW = $clog2(RECOVER_TICKS + 1),
  localparam int EW = $clog2(ERASE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmd_block,
  input  logic [BW-1:0] blk_idx,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic          cmd_reset,
  input  logic          status_rd,
  output logic          busy,
  output logic          toggle,
  output logic          window_closed,
  output logic          erasing,
  output logic          suspended,
  output logic          recovering,
  output logic [BW-1:0] cur_block
);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_ERASE, S_SUSP, S_REC} state_t;

  state_t                st;
  logic [NUM_BLOCKS-1:0] pend;
  logic [BW-1:0]         cur;
  logic [WW-1:0]         win_cnt;
  logic [RW-1:0]         rec_cnt;
  logic [EW-1:0]         ers_cnt;
  logic                  tog;

  function automatic logic [BW-1:0] lowest(input logic [NUM_BLOCKS-1:0] v);
    logic [BW-1:0] r;
    r = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--)
      if (v[i]) r = BW'(i);
    return r;
  endfunction

  logic [NUM_BLOCKS-1:0] new_bit, cur_bit, rem;
  assign new_bit = {{(NUM_BLOCKS-1){1'b0}}, 1'b1} << blk_idx;
  assign cur_bit = {{(NUM_BLOCKS-1){1'b0}}, 1'b1} << cur;
  assign rem     = pend & ~cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= '0;
      cur     <= '0;
      win_cnt <= '0;
      rec_cnt <= '0;
      ers_cnt <= '0;
      tog     <= 1'b0;
    end else begin
      if (status_rd && (st == S_WIN || st == S_ERASE)) tog <= ~tog;
      case (st)
        S_IDLE: if (cmd_block) begin
          pend    <= new_bit;
          win_cnt <= '0;
          st      <= S_WIN;
        end
        S_WIN: begin
          if (cmd_reset) begin
            st <= S_REC; pend <= '0; rec_cnt <= '0;
          end else if (cmd_block) begin
            pend    <= pend | new_bit;
            win_cnt <= '0;
          end else if (tick) begin
            if (win_cnt == WW'(WINDOW_TICKS - 1)) begin
              st      <= S_ERASE;
              cur     <= lowest(pend);
              ers_cnt <= '0;
            end else begin
              win_cnt <= win_cnt + 1'b1;
            end
          end
        end
        S_ERASE: begin
          if (cmd_reset) begin
            st <= S_REC; pend <= '0; rec_cnt <= '0;
          end else if (cmd_suspend) begin
            st <= S_SUSP;
          end else if (ers_cnt == EW'(ERASE_CYCLES - 1)) begin
            pend    <= rem;
            ers_cnt <= '0;
            if (rem == '0) st <= S_IDLE;
            else cur <= lowest(rem);
          end else begin
            ers_cnt <= ers_cnt + 1'b1;
          end
        end
        S_SUSP: begin
          if (cmd_reset) begin
            st <= S_REC; pend <= '0; rec_cnt <= '0;
          end else if (cmd_resume) begin
            st <= S_ERASE;
          end
        end
        S_REC: if (tick) begin
          if (rec_cnt == RW'(RECOVER_TICKS - 1)) st <= S_IDLE;
          else rec_cnt <= rec_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st == S_WIN) || (st == S_ERASE) || (st == S_SUSP);
  assign window_closed = (st == S_ERASE) || (st == S_SUSP);
  assign erasing       = (st == S_ERASE);
  assign suspended     = (st == S_SUSP);
  assign recovering    = (st == S_REC);
  assign toggle        = tog;
  assign cur_block     = cur;

endmodule

// File: rtl/erase_sequencer_chk.sv
module erase_sequencer_chk #(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_block,
  input logic          cmd_suspend,
  input logic          cmd_resume,
  input logic          cmd_reset,
  input logic          status_rd,
  input logic          busy,
  input logic          toggle,
  input logic          window_closed,
  input logic          erasing,
  input logic          suspended,
  input logic          recovering,
  input logic [BW-1:0] cur_block
);

  p_closed_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    window_closed |-> busy);

  p_window_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !window_closed && cmd_block && !cmd_reset) |=> (busy && !window_closed));

  p_toggle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd || suspended || !busy) |=> $stable(toggle));

  p_susp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!erasing && busy && window_closed));

  p_susp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !cmd_resume && !cmd_reset) |=> (suspended && $stable(cur_block)));

  p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && cmd_resume && !cmd_reset) |=> (erasing && $stable(cur_block)));

  p_resume_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !recovering && cmd_resume && !cmd_block) |=> !busy);

  p_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> (!busy && !suspended && !erasing));

endmodule

bind erase_sequencer erase_sequencer_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_block(cmd_block), .cmd_suspend(cmd_suspend),
  .cmd_resume(cmd_resume), .cmd_reset(cmd_reset), .status_rd(status_rd),
  .busy(busy), .toggle(toggle), .window_closed(window_closed), .erasing(erasing),
  .suspended(suspended), .recovering(recovering), .cur_block(cur_block)
);

// File: tb/erase_sequencer_bench.sv
`timescale 1ns/1ps
module erase_sequencer_bench;
  localparam int NB = 8;
  localparam int WT = 80;
  localparam int RT = 5;
  localparam int EC = 40;
  localparam int BW = $clog2(NB);

  logic clk = 0, rst_n = 0, tick = 0, cmd_block = 0, cmd_suspend = 0;
  logic cmd_resume = 0, cmd_reset = 0, status_rd = 0;
  logic [BW-1:0] blk_idx = '0;
  logic busy, toggle, window_closed, erasing, suspended, recovering;
  logic [BW-1:0] cur_block;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit abort_pending = 0;

  always #5 clk = ~clk;

  erase_sequencer #(.NUM_BLOCKS(NB), .WINDOW_TICKS(WT), .RECOVER_TICKS(RT),
                    .ERASE_CYCLES(EC)) u_erase_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_block(cmd_block), .blk_idx(blk_idx),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
    .status_rd(status_rd), .busy(busy), .toggle(toggle), .window_closed(window_closed),
    .erasing(erasing), .suspended(suspended), .recovering(recovering),
    .cur_block(cur_block));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse_block(input int idx);
    @(negedge clk); cmd_block = 1; blk_idx = BW'(idx);
    @(negedge clk); cmd_block = 0;
  endtask
  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask
  task automatic do_suspend; @(negedge clk); cmd_suspend = 1; @(negedge clk); cmd_suspend = 0; endtask
  task automatic do_resume;  @(negedge clk); cmd_resume = 1;  @(negedge clk); cmd_resume = 0;  endtask
  task automatic do_reset;   @(negedge clk); cmd_reset = 1;   @(negedge clk); cmd_reset = 0;   endtask
  task automatic do_read;    @(negedge clk); status_rd = 1;   @(negedge clk); status_rd = 0;   endtask
  task automatic idle_cycles(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_idle;
    int k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    chk("R5 busy clears after last block", busy, 0);
    chk("R5 window_closed clears", window_closed, 0);
  endtask

  // monitor: block order and active cycles per block
  logic p_act = 0, p_susp = 0;
  logic [BW-1:0] p_blk = '0;
  int act_cnt = 0, sus_cnt = 0;

  task automatic finish_blk;
    if (abort_pending) abort_pending = 0;
    else chk("R5 active cycles per block", act_cnt, EC + sus_cnt);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      act = erasing || suspended;
      if (act && (!p_act || cur_block != p_blk)) begin
        if (p_act) finish_blk();
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R5/R11 unexpected block: got %0d expected none", cur_block);
        end else begin
          chk("R5 erase order", int'(cur_block), exp_q.pop_front());
        end
        act_cnt = 0; sus_cnt = 0;
      end else if (!act && p_act) begin
        finish_blk();
      end
      if (erasing) act_cnt++;
      if (suspended && !p_susp) sus_cnt++;
      p_act = act; p_susp = suspended; p_blk = cur_block;
    end
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic t0;
    idle_cycles(3);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 toggle", toggle, 0);
    chk("R1 window_closed", window_closed, 0); chk("R1 erasing", erasing, 0);
    chk("R1 suspended", suspended, 0); chk("R1 recovering", recovering, 0);
    chk("R1 cur_block", cur_block, 0);
    rst_n = 1;
    idle_cycles(2);

    // single block
    exp_q.push_back(3);
    pulse_block(3);
    chk("R2 busy", busy, 1); chk("R2 window open", window_closed, 0); chk("R2 erasing", erasing, 0);
    do_tick(WT - 1);
    chk("R3 window still open", window_closed, 0);
    do_tick(1);
    chk("R3 window closed", window_closed, 1); chk("R3 erasing", erasing, 1);
    chk("R5 cur_block", cur_block, 3);
    wait_idle();

    // toggle idle
    t0 = toggle; do_read(); chk("R6 toggle idle holds", toggle, t0);

    // multi block with restart
    pulse_block(5);
    t0 = toggle; do_read(); chk("R6 toggle in window", toggle, !t0);
    do_tick(50);
    pulse_block(1);
    do_tick(WT - 1);
    chk("R4 restart keeps window open", window_closed, 0);
    pulse_block(6); pulse_block(1);
    exp_q.push_back(1); exp_q.push_back(5); exp_q.push_back(6);
    do_tick(WT);
    chk("R4 erase starts", erasing, 1); chk("R5 lowest first", cur_block, 1);
    t0 = toggle; do_read(); chk("R6 toggle erasing", toggle, !t0);
    t0 = toggle; do_read(); chk("R6 toggle erasing again", toggle, !t0);
    pulse_block(2);
    chk("R11 block cmd ignored in erase", cur_block, 1);
    do_suspend();
    t0 = toggle;
    chk("R7 suspended", suspended, 1);
    do_resume();
    chk("R8 resume", erasing, 1);
    wait_idle();

    // suspend/resume twice on one block
    pulse_block(7); pulse_block(0);
    exp_q.push_back(0); exp_q.push_back(7);
    do_tick(WT);
    idle_cycles(8);
    do_resume();
    chk("R9 resume no effect: suspended", suspended, 0);
    chk("R9 resume no effect: erasing", erasing, 1);
    do_suspend();
    chk("R7 suspended", suspended, 1); chk("R7 erasing low", erasing, 0);
    chk("R7 busy", busy, 1); chk("R7 cur_block", cur_block, 0);
    t0 = toggle; do_read(); chk("R6 toggle holds suspended", toggle, t0);
    do_suspend();
    chk("R7 repeat suspend ignored", suspended, 1);
    idle_cycles(30);
    chk("R7 still suspended", suspended, 1); chk("R7 cur_block held", cur_block, 0);
    pulse_block(4);
    do_resume();
    chk("R8 erasing again", erasing, 1); chk("R8 same block", cur_block, 0);
    idle_cycles(5);
    do_suspend(); chk("R8 suspend again", suspended, 1);
    idle_cycles(3);
    do_resume(); chk("R8 resume again", erasing, 1);
    wait_idle();

    // resume in idle, suspend in idle, reset in idle
    do_resume(); chk("R9 resume idle busy", busy, 0); chk("R9 resume idle susp", suspended, 0);
    do_suspend(); chk("R7 suspend idle ignored", suspended, 0);
    do_reset(); chk("R10 reset idle no recovery", recovering, 0);

    // reset during erase
    pulse_block(2);
    exp_q.push_back(2);
    do_tick(WT);
    idle_cycles(5);
    abort_pending = 1;
    do_reset();
    chk("R10 recovering", recovering, 1); chk("R10 busy low", busy, 0);
    chk("R10 erasing low", erasing, 0);
    pulse_block(3);
    chk("R10 block ignored in recovery", busy, 0);
    do_tick(RT - 1);
    chk("R10 still recovering", recovering, 1);
    do_tick(1);
    chk("R10 recovery done", recovering, 0); chk("R10 pending dropped", busy, 0);
    pulse_block(4);
    exp_q.push_back(4);
    chk("R2 accepted after recovery", busy, 1);
    do_tick(WT);
    chk("R10 new erase block", cur_block, 4);
    wait_idle();

    chk("R5 all expected blocks erased", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule